// File: doc/BRIEF.md
# Retire-Ordered Store Buffer with Fences

This block sits between an in-order memory pipeline and the write port of a coherent data cache. Executed stores wait in a private circular buffer. The pipeline retires them one at a time, oldest first. Retired stores then leave for the cache, one per cycle, in exactly the order they were enqueued. Loads do not wait for buffered stores. A load reads the cache directly unless a buffered store from the same core touches its bytes. In that case the youngest such store either supplies the data or, if it covers only part of the load, holds the load back until that store has been written out.

Two fence flavours control ordering. A full fence waits until the buffer is completely empty. While it waits, every later load and store is held off. A store fence is the lighter one: it waits until no non-temporal store remains buffered, and it holds off only later stores. A flush input discards the stores that have not yet retired in a single cycle. Retired stores are kept and still drain. The `empty` output lets the pipeline see when nothing is held.

All addresses are word addresses. Byte-enable bit i selects byte i of the data word, which is bits 8i+7 down to 8i.

Top module: `store_buffer`

## Requirements
- R1: Retired stores appear on the cache write port strictly in the order they were accepted on the enqueue port, carrying that store's address, data, byte enables and non-temporal flag.
- R2: `wr_valid` is asserted only for the oldest held store and only once it has retired. A `retire` pulse marks the oldest not-yet-retired store as retired. A `retire` pulse when every held store has already retired changes nothing.
- R3: A load whose word address matches no held store with overlapping byte enables is ready at once (`ld_ready`=1, `ld_fwd`=0), even while other stores are held.
- R4: When the youngest held store that overlaps the load's bytes covers all of them, the load is ready with `ld_fwd`=1. `ld_data` carries that store's bytes in the requested lanes and zero in the other lanes.
- R5: When that youngest overlapping store covers only some of the load's bytes, `ld_ready` stays 0 until that store has left the buffer.
- R6: With `fence_valid`=1 and `fence_full`=1, `fence_done` rises only when no store is held. Until then, `enq_ready` and `ld_ready` are both 0.
- R7: With `fence_valid`=1 and `fence_full`=0, `fence_done` rises only when no non-temporal store is held. Until then, `enq_ready` is 0 while loads are unaffected.
- R8: `enq_ready` is 0 whenever DEPTH stores are held or `flush` is 1. An enqueue that is not ready is discarded.
- R9: At most one store is offered per cycle. Once `wr_valid` is high without `wr_ready`, the same store stays offered with unchanged payload in the next cycle.
- R10: A `flush` pulse removes every store that is not retired by the end of that cycle (a `retire` in the same cycle counts) and keeps all retired ones.
- R11: `empty` is 1 exactly when no store is held; out of reset it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enq_valid | input | 1 | Store from the execute stage |
| enq_ready | output | 1 | Store accepted this cycle |
| enq_addr | input | ADDR_W | Store word address |
| enq_data | input | DATA_W | Store data |
| enq_be | input | DATA_W/8 | Store byte enables |
| enq_nt | input | 1 | Store is non-temporal |
| retire | input | 1 | Oldest unretired store has retired |
| flush | input | 1 | Drop all unretired stores |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load word address |
| ld_be | input | DATA_W/8 | Load byte enables |
| ld_ready | output | 1 | Load may complete this cycle |
| ld_fwd | output | 1 | Load data comes from the buffer |
| ld_data | output | DATA_W | Forwarded load data |
| fence_valid | input | 1 | Fence waiting at the memory stage |
| fence_full | input | 1 | 1: full fence, 0: store fence |
| fence_done | output | 1 | Fence condition met |
| wr_valid | output | 1 | Cache write offered |
| wr_ready | input | 1 | Cache accepts the write |
| wr_addr | output | ADDR_W | Cache write word address |
| wr_data | output | DATA_W | Cache write data |
| wr_be | output | DATA_W/8 | Cache write byte enables |
| wr_nt | output | 1 | Cache write is non-temporal |
| empty | output | 1 | No store held |

## Verification
Two events collide most often. The first is a drain to the cache in the same cycle as a new enqueue. The second is a `retire` in the same cycle as a `flush`. Directed sequences create both on purpose, and a long random phase with small address ranges and frequent fences repeats them many times. The reference model applies each cycle's events in a fixed order: retire, then flush, then drain, then enqueue. The next cycle's `empty`, write port, load answers and fence status must then match that model. A flush in the same cycle as a retire must therefore keep the newly retired store.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Where a load's bytes come from.
  typedef enum logic [1:0] {
    LD_CACHE = 2'd0,
    LD_FWD   = 2'd1,
    LD_WAIT  = 2'd2
  } ld_path_e;

  typedef enum logic {
    FENCE_STORE = 1'b0,
    FENCE_FULL  = 1'b1
  } fence_kind_e;

endpackage

// File: rtl/sb_queue.sv
// Circular store storage with three pointers: head (oldest), rptr (next to retire), tail (next free).
module sb_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic [BE_W-1:0]   push_be,
  input  logic              push_nt,
  input  logic              retire,
  input  logic              pop,
  input  logic              flush,
  output logic [IW-1:0]     head_idx,
  output logic [CW-1:0]     held_cnt,
  output logic [CW-1:0]     ret_cnt,
  output logic [ADDR_W-1:0] slot_addr [DEPTH],
  output logic [DATA_W-1:0] slot_data [DEPTH],
  output logic [BE_W-1:0]   slot_be   [DEPTH],
  output logic              slot_nt   [DEPTH],
  output logic              slot_ret  [DEPTH]
);

  logic [CW-1:0] head_q, tail_q, rptr_q, rptr_n;
  logic          retire_eff;

  function automatic logic [IW-1:0] slot_of(input logic [CW-1:0] p);
    return p[IW-1:0];
  endfunction

  assign head_idx   = slot_of(head_q);
  assign held_cnt   = tail_q - head_q;
  assign ret_cnt    = rptr_q - head_q;
  assign retire_eff = retire && (rptr_q != tail_q);
  assign rptr_n     = rptr_q + CW'(retire_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      rptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        slot_addr[i] <= '0;
        slot_data[i] <= '0;
        slot_be[i]   <= '0;
        slot_nt[i]   <= 1'b0;
        slot_ret[i]  <= 1'b0;
      end
    end else begin
      if (push) begin
        slot_addr[slot_of(tail_q)] <= push_addr;
        slot_data[slot_of(tail_q)] <= push_data;
        slot_be[slot_of(tail_q)]   <= push_be;
        slot_nt[slot_of(tail_q)]   <= push_nt;
        slot_ret[slot_of(tail_q)]  <= 1'b0;
      end
      if (retire_eff) slot_ret[slot_of(rptr_q)] <= 1'b1;
      if (pop) head_q <= head_q + CW'(1);
      if (flush) tail_q <= rptr_n;
      else if (push) tail_q <= tail_q + CW'(1);
      rptr_q <= rptr_n;
    end
  end

endmodule

// File: rtl/sb_scan.sv
// Age-ordered search of the held stores for the load lookup and the non-temporal count.
module sb_scan
  import sb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = IW + 1
) (
  input  logic [IW-1:0]     head_idx,
  input  logic [CW-1:0]     held_cnt,
  input  logic [ADDR_W-1:0] slot_addr [DEPTH],
  input  logic [DATA_W-1:0] slot_data [DEPTH],
  input  logic [BE_W-1:0]   slot_be   [DEPTH],
  input  logic              slot_nt   [DEPTH],
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BE_W-1:0]   ld_be,
  output ld_path_e          ld_path,
  output logic [DATA_W-1:0] ld_data,
  output logic [CW-1:0]     nt_held
);

  function automatic logic [DATA_W-1:0] lane_mask(input logic [BE_W-1:0] be);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < BE_W; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic logic be_covers(input logic [BE_W-1:0] st, input logic [BE_W-1:0] ld);
    return (st & ld) == ld;
  endfunction

  logic [IW-1:0] sidx [DEPTH];
  logic [DEPTH-1:0] live, hit;

  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    assign sidx[k] = head_idx + IW'(k);
    assign live[k] = CW'(k) < held_cnt;
    assign hit[k]  = live[k] && (slot_addr[sidx[k]] == ld_addr) &&
                     ((slot_be[sidx[k]] & ld_be) != '0);
  end

  logic          found;
  logic [IW-1:0] young;

  always_comb begin
    found = 1'b0;
    young = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (hit[k]) begin
        found = 1'b1;
        young = sidx[k];
      end
    end
  end

  always_comb begin
    ld_data = '0;
    if (!found) ld_path = LD_CACHE;
    else if (be_covers(slot_be[young], ld_be)) begin
      ld_path = LD_FWD;
      ld_data = slot_data[young] & lane_mask(ld_be);
    end else ld_path = LD_WAIT;
  end

  always_comb begin
    nt_held = '0;
    for (int k = 0; k < DEPTH; k++)
      if (live[k] && slot_nt[sidx[k]]) nt_held = nt_held + CW'(1);
  end

endmodule

// File: rtl/store_buffer.sv
module store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [DATA_W-1:0] enq_data,
  input  logic [BE_W-1:0]   enq_be,
  input  logic              enq_nt,
  input  logic              retire,
  input  logic              flush,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BE_W-1:0]   ld_be,
  output logic              ld_ready,
  output logic              ld_fwd,
  output logic [DATA_W-1:0] ld_data,
  input  logic              fence_valid,
  input  logic              fence_full,
  output logic              fence_done,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [BE_W-1:0]   wr_be,
  output logic              wr_nt,
  output logic              empty
);

  logic [IW-1:0]     head_idx;
  logic [CW-1:0]     held_cnt, ret_cnt, nt_held;
  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];
  logic [BE_W-1:0]   slot_be   [DEPTH];
  logic              slot_nt   [DEPTH];
  logic              slot_ret  [DEPTH];
  ld_path_e          ld_path;
  fence_kind_e       fence_kind;

  // Named internal events.
  logic push_fire, pop_fire, head_retired, fence_met, fence_wait, ld_blocked;

  assign fence_kind   = fence_kind_e'(fence_full);
  assign empty        = (held_cnt == '0);
  assign fence_met    = (fence_kind == FENCE_FULL) ? empty : (nt_held == '0);
  assign fence_done   = fence_valid && fence_met;
  assign fence_wait   = fence_valid && !fence_met;
  assign ld_blocked   = fence_valid && (fence_kind == FENCE_FULL) && !empty;

  assign enq_ready    = (held_cnt < CW'(DEPTH)) && !flush && !fence_wait;
  assign push_fire    = enq_valid && enq_ready;

  assign head_retired = !empty && slot_ret[head_idx];
  assign wr_valid     = head_retired;
  assign wr_addr      = slot_addr[head_idx];
  assign wr_data      = slot_data[head_idx];
  assign wr_be        = slot_be[head_idx];
  assign wr_nt        = slot_nt[head_idx];
  assign pop_fire     = wr_valid && wr_ready;

  assign ld_ready     = ld_valid && (ld_path != LD_WAIT) && !ld_blocked;
  assign ld_fwd       = ld_ready && (ld_path == LD_FWD);

  sb_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_fire),
    .push_addr (enq_addr),
    .push_data (enq_data),
    .push_be   (enq_be),
    .push_nt   (enq_nt),
    .retire    (retire),
    .pop       (pop_fire),
    .flush     (flush),
    .head_idx  (head_idx),
    .held_cnt  (held_cnt),
    .ret_cnt   (ret_cnt),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .slot_be   (slot_be),
    .slot_nt   (slot_nt),
    .slot_ret  (slot_ret)
  );

  sb_scan #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_scan (
    .head_idx  (head_idx),
    .held_cnt  (held_cnt),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .slot_be   (slot_be),
    .slot_nt   (slot_nt),
    .ld_addr   (ld_addr),
    .ld_be     (ld_be),
    .ld_path   (ld_path),
    .ld_data   (ld_data),
    .nt_held   (nt_held)
  );

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enq_ready,
  input logic              ld_ready,
  input logic              fence_valid,
  input logic              fence_full,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              flush,
  input logic              empty,
  input logic [CW-1:0]     held_cnt,
  input logic [CW-1:0]     ret_cnt,
  input logic [CW-1:0]     nt_held
);

  assert_drain_retired_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (ret_cnt != '0));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enq_ready |-> (held_cnt < CW'(DEPTH)));

  assert_full_fence_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_valid && fence_full && !empty) |-> (!enq_ready && !ld_ready));

  assert_store_fence_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_valid && !fence_full && nt_held != '0) |-> !enq_ready);

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_flush_keeps_retired_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (held_cnt == ret_cnt));

  assert_empty_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!wr_valid && nt_held == '0));

endmodule

bind store_buffer sb_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enq_ready   (enq_ready),
  .ld_ready    (ld_ready),
  .fence_valid (fence_valid),
  .fence_full  (fence_full),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .flush       (flush),
  .empty       (empty),
  .held_cnt    (held_cnt),
  .ret_cnt     (ret_cnt),
  .nt_held     (nt_held)
);

// File: tb/test_store_buffer.sv
`timescale 1ns/1ps
module test_store_buffer;

  localparam int DEPTH = 8;
  localparam int AW = 30;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid, enq_ready, enq_nt, retire, flush;
  logic [AW-1:0] enq_addr, ld_addr, wr_addr;
  logic [DW-1:0] enq_data, ld_data, wr_data;
  logic [3:0] enq_be, ld_be, wr_be;
  logic ld_valid, ld_ready, ld_fwd, fence_valid, fence_full, fence_done;
  logic wr_valid, wr_ready, wr_nt, empty;

  always #2 clk = ~clk;

  store_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) i_store_buffer (.*);

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [3:0] be;
    bit nt;
    bit r;
  } ent_t;

  ent_t q[$];
  int checks = 0, fails = 0;
  bit prev_flush = 0, prev_stall = 0;

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clr();
    enq_valid = 0; enq_addr = '0; enq_data = '0; enq_be = '0; enq_nt = 0;
    retire = 0; flush = 0; ld_valid = 0; ld_addr = '0; ld_be = '0;
    fence_valid = 0; fence_full = 0; wr_ready = 0;
  endtask

  // Compare one cycle against the model, then advance the model at the clock edge.
  task automatic step();
    int n, ntc, y, path;
    bit fwait, fblk, e_enq, e_wrv, e_ldr, e_fwd, fire_wr, fire_enq;
    logic [DW-1:0] e_data;
    string t;
    #1;
    n = q.size();
    ntc = 0;
    foreach (q[i]) if (q[i].nt) ntc++;
    fwait = fence_valid && (fence_full ? (n != 0) : (ntc != 0));
    fblk  = fence_valid && fence_full && (n != 0);
    e_enq = (n < DEPTH) && !flush && !fwait;
    e_wrv = (n > 0) && q[0].r;
    y = -1;
    for (int i = n - 1; i >= 0; i--)
      if (q[i].a == ld_addr && (q[i].be & ld_be) != 0) begin y = i; break; end
    path = (y < 0) ? 0 : (((q[y].be & ld_be) == ld_be) ? 1 : 2);
    e_ldr = ld_valid && path != 2 && !fblk;
    e_fwd = e_ldr && path == 1;
    e_data = '0;
    if (e_fwd)
      for (int b = 0; b < 4; b++) if (ld_be[b]) e_data[8*b +: 8] = q[y].d[8*b +: 8];

    chk(prev_flush ? "R10 empty" : "R11 empty", 96'(empty), 96'(n == 0));
    t = fwait ? (fence_full ? "R6 enq_ready" : "R7 enq_ready") : "R8 enq_ready";
    chk(t, 96'(enq_ready), 96'(e_enq));
    chk("R2 wr_valid", 96'(wr_valid), 96'(e_wrv));
    if (e_wrv)
      chk(prev_stall ? "R9 wr payload" : "R1 wr payload",
          {29'd0, wr_nt, wr_be, wr_data, wr_addr}, {29'd0, q[0].nt, q[0].be, q[0].d, q[0].a});
    if (ld_valid) begin
      t = fblk ? "R6 ld" : (path == 0 ? "R3 ld" : (path == 1 ? "R4 ld" : "R5 ld"));
      chk(t, {ld_ready, ld_fwd}, {e_ldr, e_fwd});
      if (e_fwd) chk("R4 ld_data", 96'(ld_data), 96'(e_data));
    end
    if (fence_valid)
      chk(fence_full ? "R6 fence_done" : "R7 fence_done", 96'(fence_done), 96'(!fwait));

    fire_wr  = e_wrv && wr_ready;
    fire_enq = enq_valid && e_enq;
    @(posedge clk);
    if (retire)
      foreach (q[i]) if (!q[i].r) begin q[i].r = 1; break; end
    if (flush) while (q.size() > 0 && !q[q.size()-1].r) void'(q.pop_back());
    if (fire_wr) void'(q.pop_front());
    if (fire_enq) q.push_back('{a: enq_addr, d: enq_data, be: enq_be, nt: enq_nt, r: 0});
    prev_flush = flush;
    prev_stall = e_wrv && !wr_ready;
    @(negedge clk);
  endtask

  task automatic push(int a, logic [31:0] d, logic [3:0] be, bit nt);
    clr();
    enq_valid = 1; enq_addr = AW'(a); enq_data = d; enq_be = be; enq_nt = nt;
    step();
  endtask

  task automatic load(int a, logic [3:0] be);
    clr();
    ld_valid = 1; ld_addr = AW'(a); ld_be = be;
    step();
  endtask

  task automatic drain();
    for (int i = 0; i < 20; i++) begin clr(); retire = 1; wr_ready = 1; step(); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    clr(); step();                                  // reset state R11
    // R2, R4, R3, R5
    push(1, 32'hA1A1_A1A1, 4'hF, 0);
    push(2, 32'hB2B2_B2B2, 4'hF, 0);
    clr(); wr_ready = 1; step();                    // nothing retired, no write R2
    push(1, 32'hA2A2_A2A2, 4'hF, 0);
    load(1, 4'hF);                                  // youngest of two R4
    load(5, 4'hF);                                  // no match R3
    load(2, 4'h3);                                  // subset R4
    push(3, 32'hC3C3_C3C3, 4'h3, 0);
    load(3, 4'hF);                                  // partial R5
    load(3, 4'h1);
    // drain with back-pressure R9, R1, concurrent push and drain
    clr(); retire = 1; step();
    clr(); retire = 1; step();
    clr(); retire = 1; wr_ready = 1; enq_valid = 1; enq_addr = 9; enq_data = 32'h0909_0909; enq_be = 4'hF; step();
    for (int i = 0; i < 6; i++) begin
      clr(); retire = 1; wr_ready = (i != 1); ld_valid = 1; ld_addr = 3; ld_be = 4'hF; step();
    end
    drain();
    // store fence with non-temporal stores R7
    push(7, 32'h7777_0000, 4'hF, 1);
    push(8, 32'h8888_0000, 4'hF, 0);
    for (int i = 0; i < 3; i++) begin
      clr(); fence_valid = 1; enq_valid = 1; enq_addr = 4; enq_be = 4'hF;
      ld_valid = 1; ld_addr = 6; ld_be = 4'hF; step();
    end
    for (int i = 0; i < 5; i++) begin
      clr(); fence_valid = 1; retire = 1; wr_ready = 1; enq_valid = 1; enq_addr = 4;
      enq_data = 32'h4444_4444; enq_be = 4'hF; step();
    end
    drain();
    // full fence R6
    push(10, 32'h1010_1010, 4'hF, 0);
    push(11, 32'h1111_1111, 4'hF, 0);
    for (int i = 0; i < 3; i++) begin
      clr(); fence_valid = 1; fence_full = 1; enq_valid = 1; enq_addr = 12; enq_be = 4'hF;
      ld_valid = 1; ld_addr = 40; ld_be = 4'hF; step();
    end
    for (int i = 0; i < 6; i++) begin
      clr(); fence_valid = 1; fence_full = 1; retire = 1; wr_ready = 1;
      ld_valid = 1; ld_addr = 40; ld_be = 4'hF; step();
    end
    // flush with a retire in the same cycle R10
    push(20, 32'h2020_2020, 4'hF, 0);
    push(21, 32'h2121_2121, 4'hF, 0);
    push(22, 32'h2222_2222, 4'hF, 0);
    clr(); retire = 1; step();
    clr(); retire = 1; flush = 1; enq_valid = 1; enq_addr = 23; enq_be = 4'hF; step();
    load(22, 4'hF);
    drain();
    push(30, 32'h3030_3030, 4'hF, 0);
    clr(); flush = 1; step();
    clr(); step();
    // fill R8
    for (int i = 0; i < DEPTH + 2; i++) push(50 + i, 32'(i), 4'hF, 0);
    clr(); flush = 1; step();
    clr(); step();
    // random mix
    for (int c = 0; c < 4000; c++) begin
      clr();
      enq_valid = ($urandom_range(0, 2) != 0);
      enq_addr = AW'($urandom_range(0, 5));
      enq_data = $urandom();
      enq_be = 4'($urandom_range(1, 15));
      enq_nt = ($urandom_range(0, 5) == 0);
      retire = ($urandom_range(0, 1) == 1);
      flush = ($urandom_range(0, 39) == 0);
      ld_valid = ($urandom_range(0, 1) == 1);
      ld_addr = AW'($urandom_range(0, 6));
      ld_be = 4'($urandom_range(1, 15));
      fence_valid = ($urandom_range(0, 9) == 0);
      fence_full = ($urandom_range(0, 1) == 1);
      wr_ready = ($urandom_range(0, 3) != 0);
      step();
    end
    drain();
    clr(); step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule